// File: doc/BRIEF.md
# Byte-access controller for a word-organised three-wire serial EEPROM

This block is a hardware master. It gives a requester byte-granular read and write access to a 1-Kbit serial EEPROM with three data wires. The memory is organised as 64 words of 16 bits, and the controller drives its chip select, serial clock and input data line, and samples its output data line. A requester presents a one-cycle start pulse together with a direction, a byte offset and, for a write, the byte to store. The block answers with a one-cycle done pulse, a result byte and an error flag.

Byte writes have to be emulated on the word-organised part. A write request first sends the write-enable command. It then reads the whole word holding the target byte, replaces only the addressed half and writes the merged word back. After that it polls the memory's ready status in a frame of its own, and it ends with the write-disable command. Every command travels in a separate chip-select frame, and each frame is followed by a minimum chip-select-low gap. Reads need a single frame.

The sequencer has six states. IDLE waits for a request. ENA sends the enable command, RDW performs the word read, WRW sends the merged word, POLL waits for ready and DIS sends the disable command. The transitions are as follows:
- IDLE goes to RDW on an accepted read and to ENA on an accepted write.
- ENA goes to RDW.
- RDW returns to IDLE for a read and goes on to WRW for a write.
- WRW goes to POLL.
- POLL goes to DIS when the memory reports ready, and to IDLE on a timeout.
- DIS goes to IDLE.

A frame engine below the sequencer has its own states: E_IDLE, E_LO, E_HI, E_POLL and E_GAP.

Top module: `mw_byte_eeprom`

## Requirements
- R1: Chip select, serial clock, data-to-memory, busy and done are all low after reset. Chip select, serial clock and data-to-memory stay low whenever busy is low.
- R2: A read of byte offset o returns word o/2 in rdata, with done high for one cycle and err low. An odd offset returns bits 15:8 of the word and an even offset returns bits 7:0.
- R3: Every command frame begins with a 9-bit header sent MSB first: a start bit of 1, a 2-bit opcode and a 6-bit word address. The opcodes are read 10, write 01, enable 00 with address 11xxxx, and disable 00 with address 00xxxx. A read frame uses 26 clocks, and the word is assembled from the last 16 bits sampled, so the dummy zero that follows the header is discarded. A write frame uses 25 clocks.
- R4: The serial clock is high only while chip select is high. The data-to-memory line does not change while the serial clock is high; it changes only on falling edges. The memory output is sampled on the rising edge.
- R5: A byte write changes only the addressed half of word o/2 and keeps the other half of that word.
- R6: A write request produces exactly five frames in this order: enable (9 clocks), read (26), write (25), ready poll (no clocks) and disable (9). The memory therefore ends the request write-disabled.
- R7: The ready poll holds chip select high until the memory output reads 1. Every return to idle is marked by a done pulse.
- R8: If the memory stays busy for TMO cycles of the poll, the request aborts. It gives done with err high, chip select low, and no disable frame, for four frames in total.
- R9: A request whose offset is 128 or more is answered in the next cycle with done and err high, and the pins are not touched.
- R10: A start pulse while busy is high is ignored. It produces no extra done pulse and no memory change.
- R11: Chip select stays low for at least GAP system-clock cycles between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse |
| wr | input | 1 | 1 = byte write, 0 = byte read |
| off | input | ADDR_W+2 | Byte offset |
| wdata | input | 8 | Byte to write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with done |
| rdata | output | 8 | Read result, valid with done |
| mw_cs | output | 1 | Memory chip select, active high |
| mw_sclk | output | 1 | Memory serial clock |
| mw_mosi | output | 1 | Data to the memory |
| mw_miso | input | 1 | Data from the memory |

## Verification
The bench builds the block with its full 6-bit word address and a half-period of 2 system clocks. It also uses a 3-cycle frame gap and a poll limit of 300 cycles against a behavioural memory that stays busy for 60 cycles. This configuration makes a sweep over all 128 byte offsets affordable: every offset is read, written and read back. The short poll limit lets a stuck-busy memory reach the timeout abort quickly. Offsets from 128 up to 255 then cover the rejection path.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {T_IDLE, T_ENA, T_RDW, T_WRW, T_POLL, T_DIS} top_st_t;
    typedef enum logic [2:0] {E_IDLE, E_LO, E_HI, E_POLL, E_GAP} eng_st_t;
    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [1:0] OP_EX = 2'b00;
endpackage

// File: rtl/mw_lane.sv
module mw_lane #(
    parameter int BW = 8
) (
    input  logic [2*BW-1:0] word_in,
    input  logic [BW-1:0]   byte_in,
    input  logic            hi,
    output logic [BW-1:0]   rd_byte,
    output logic [2*BW-1:0] merged
);
    always_comb begin
        if (hi) begin
            rd_byte = word_in[2*BW-1:BW];
            merged  = {byte_in, word_in[BW-1:0]};
        end else begin
            rd_byte = word_in[BW-1:0];
            merged  = {word_in[2*BW-1:BW], byte_in};
        end
    end
endmodule

// File: rtl/mw_frame.sv
module mw_frame import mw_pkg::*; #(
    parameter int TXW  = 26,
    parameter int NBW  = 5,
    parameter int DW   = 16,
    parameter int HALF = 4,
    parameter int GAP  = 4,
    parameter int TMO  = 50000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic           poll,
    input  logic [NBW-1:0] nbits,
    input  logic [TXW-1:0] tx,
    input  logic           miso,
    output logic           cs,
    output logic           sclk,
    output logic           mosi,
    output logic [DW-1:0]  rx,
    output logic           fin,
    output logic           tmo
);
    localparam int M1 = (HALF > GAP) ? HALF : GAP;
    localparam int MX = (M1 > TMO) ? M1 : TMO;
    localparam int CW = $clog2(MX + 1);
    localparam logic [CW-1:0] H_END = CW'(HALF - 1);
    localparam logic [CW-1:0] G_END = CW'(GAP - 1);
    localparam logic [CW-1:0] T_END = CW'(TMO - 1);

    eng_st_t        st, st_n;
    logic [CW-1:0]  cnt;
    logic [NBW-1:0] bitn;
    logic [TXW-1:0] sh;

    always_comb begin
        st_n = st;
        unique case (st)
            E_IDLE: if (go) st_n = poll ? E_POLL : E_LO;
            E_LO:   if (cnt == H_END) st_n = E_HI;
            E_HI:   if (cnt == H_END) st_n = (bitn == NBW'(1)) ? E_GAP : E_LO;
            E_POLL: if (miso || cnt == T_END) st_n = E_GAP;
            E_GAP:  if (cnt == G_END) st_n = E_IDLE;
            default: st_n = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= E_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            rx   <= '0;
            fin  <= 1'b0;
            tmo  <= 1'b0;
        end else begin
            if (st_n != st || st == E_IDLE) cnt <= '0;
            else                            cnt <= cnt + 1'b1;
            fin <= (st == E_GAP) && (cnt == G_END);
            if (st == E_IDLE && go) begin
                sh   <= tx;
                bitn <= nbits;
                tmo  <= 1'b0;
            end
            if (st == E_LO && cnt == H_END) rx <= {rx[DW-2:0], miso};
            if (st == E_HI && cnt == H_END) begin
                sh   <= {sh[TXW-2:0], 1'b0};
                bitn <= bitn - 1'b1;
            end
            if (st == E_POLL && !miso && cnt == T_END) tmo <= 1'b1;
        end
    end

    always_comb begin
        cs   = (st == E_LO) || (st == E_HI) || (st == E_POLL);
        sclk = (st == E_HI);
        mosi = ((st == E_LO) || (st == E_HI)) && sh[TXW-1];
    end
endmodule

// File: rtl/mw_byte_eeprom.sv
module mw_byte_eeprom import mw_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter int HALF   = 4,
    parameter int GAP    = 4,
    parameter int TMO    = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [ADDR_W+1:0] off,
    input  logic [7:0]        wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [7:0]        rdata,
    output logic              mw_cs,
    output logic              mw_sclk,
    output logic              mw_mosi,
    input  logic              mw_miso
);
    localparam int BW     = 8;
    localparam int DW     = 2 * BW;
    localparam int OFF_W  = ADDR_W + 2;
    localparam int NBYTES = 2 ** (ADDR_W + 1);
    localparam int HDR    = 3 + ADDR_W;
    localparam int TXW    = HDR + DW + 1;
    localparam int NBW    = $clog2(TXW + 1);

    top_st_t          st, st_n;
    logic [ADDR_W:0]  off_q;
    logic             wr_q, go_q, fin, tmo, bad, poll_en;
    logic [BW-1:0]    wb_q, lane_rd;
    logic [DW-1:0]    word_q, rx, lane_mrg, data;
    logic [1:0]       op;
    logic [ADDR_W-1:0] waddr;
    logic [NBW-1:0]   nb;
    logic [TXW-1:0]   tx;

    assign bad     = (off >= OFF_W'(NBYTES));
    assign poll_en = (st == T_POLL);
    assign busy    = (st != T_IDLE);

    always_comb begin
        st_n = st;
        unique case (st)
            T_IDLE: if (start && !bad) st_n = wr ? T_ENA : T_RDW;
            T_ENA:  if (fin) st_n = T_RDW;
            T_RDW:  if (fin) st_n = wr_q ? T_WRW : T_IDLE;
            T_WRW:  if (fin) st_n = T_POLL;
            T_POLL: if (fin) st_n = tmo ? T_IDLE : T_DIS;
            T_DIS:  if (fin) st_n = T_IDLE;
            default: st_n = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= T_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        op    = OP_EX;
        waddr = off_q[ADDR_W:1];
        nb    = '0;
        data  = '0;
        unique case (st)
            T_ENA: begin waddr = {2'b11, {(ADDR_W-2){1'b0}}}; nb = NBW'(HDR); end
            T_DIS: begin waddr = '0; nb = NBW'(HDR); end
            T_RDW: begin op = OP_RD; nb = NBW'(HDR + DW + 1); end
            T_WRW: begin op = OP_WR; nb = NBW'(HDR + DW); data = word_q; end
            default: nb = '0;
        endcase
        tx = {1'b1, op, waddr, data, 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= '0;
            wr_q   <= 1'b0;
            wb_q   <= '0;
            word_q <= '0;
            rdata  <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            go_q   <= 1'b0;
        end else begin
            done <= 1'b0;
            go_q <= (st_n != st) && (st_n != T_IDLE);
            unique case (st)
                T_IDLE: if (start) begin
                    if (bad) begin
                        done <= 1'b1;
                        err  <= 1'b1;
                    end else begin
                        off_q <= off[ADDR_W:0];
                        wr_q  <= wr;
                        wb_q  <= wdata;
                    end
                end
                T_RDW: if (fin) begin
                    if (wr_q) word_q <= lane_mrg;
                    else begin
                        rdata <= lane_rd;
                        done  <= 1'b1;
                        err   <= 1'b0;
                    end
                end
                T_POLL: if (fin && tmo) begin
                    done <= 1'b1;
                    err  <= 1'b1;
                end
                T_DIS: if (fin) begin
                    done <= 1'b1;
                    err  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    mw_lane #(.BW(BW)) u_lane (
        .word_in(rx), .byte_in(wb_q), .hi(off_q[0]),
        .rd_byte(lane_rd), .merged(lane_mrg)
    );

    mw_frame #(
        .TXW(TXW), .NBW(NBW), .DW(DW), .HALF(HALF), .GAP(GAP), .TMO(TMO)
    ) u_frm (
        .clk(clk), .rst_n(rst_n), .go(go_q), .poll(poll_en), .nbits(nb),
        .tx(tx), .miso(mw_miso), .cs(mw_cs), .sclk(mw_sclk), .mosi(mw_mosi),
        .rx(rx), .fin(fin), .tmo(tmo)
    );
endmodule

// File: rtl/mw_byte_eeprom_chk.sv
module mw_byte_eeprom_chk #(
    parameter int OFF_W  = 8,
    parameter int NBYTES = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [OFF_W-1:0] off,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             mw_cs,
    input logic             mw_sclk,
    input logic             mw_mosi
);
    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mw_cs && !mw_sclk && !mw_mosi));
    // R4
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mw_sclk |-> mw_cs);
    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mw_sclk && $past(mw_sclk)) |-> $stable(mw_mosi));
    // R7
    done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R9
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (off >= OFF_W'(NBYTES))) |=> (done && err && !mw_cs));
endmodule

bind mw_byte_eeprom mw_byte_eeprom_chk #(.OFF_W(OFF_W), .NBYTES(NBYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .off(off), .busy(busy),
    .done(done), .err(err), .mw_cs(mw_cs), .mw_sclk(mw_sclk), .mw_mosi(mw_mosi)
);

// File: tb/sim_mw_byte_eeprom.sv
module sim_mw_byte_eeprom;
    localparam int AW = 6, HALF = 2, GAP = 3, TMO = 300, BUSY = 60;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, wr = 1'b0;
    logic [7:0] off = '0, wdata = '0;
    logic busy, done, err, cs, sclk, mosi, miso;
    logic [7:0] rdata;

    always #10 clk = ~clk;

    mw_byte_eeprom #(.ADDR_W(AW), .HALF(HALF), .GAP(GAP), .TMO(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .wr(wr), .off(off), .wdata(wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .mw_cs(cs), .mw_sclk(sclk), .mw_mosi(mosi), .mw_miso(miso)
    );

    int total = 0, bad = 0;
    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] wf(input int i);
        return 16'(i * 291) ^ 16'h5AA5;
    endfunction

    // behavioural memory
    logic [15:0] mem [64];
    logic [15:0] expm [64];
    logic cs_q, sk_q, mo_q, rd_phase, rbit;
    int bitcnt, busy_left, frames, fidx, low_run, viol;
    int min_low = 1000;
    int lens [2048];
    logic [8:0] hdr;
    logic [15:0] wdat, rword;
    bit stuck = 0, wen, seen_fall;
    int done_cnt = 0;

    assign miso = rd_phase ? rbit : (cs && busy_left == 0);

    always @(posedge clk) if (done) done_cnt++;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] = wf(i);
            cs_q <= 0; sk_q <= 0; mo_q <= 0; rd_phase <= 0; rbit <= 0;
            busy_left <= 0; bitcnt = 0; frames = 0; fidx = 0; low_run = 0;
            viol = 0; wen = 0; seen_fall = 0;
        end else begin
            cs_q <= cs; sk_q <= sclk; mo_q <= mosi;
            if (sclk && sk_q && mosi !== mo_q) viol++;
            if (busy_left > 0 && !stuck) busy_left <= busy_left - 1;
            if (cs && !cs_q) begin
                bitcnt = 0; rd_phase <= 0; frames++;
                if (seen_fall && low_run < min_low) min_low = low_run;
            end
            if (!cs) low_run++;
            if (cs && sclk && !sk_q) begin
                bitcnt++;
                if (bitcnt <= 9) hdr = {hdr[7:0], mosi};
                else if (bitcnt <= 25) wdat = {wdat[14:0], mosi};
                if (bitcnt == 9 && hdr[8] && hdr[7:6] == 2'b10) begin
                    rword = mem[hdr[5:0]]; rd_phase <= 1; rbit <= 0;
                end else if (bitcnt >= 10 && bitcnt <= 25) rbit <= rword[25-bitcnt];
            end
            if (!cs && cs_q) begin
                seen_fall = 1; low_run = 0; rd_phase <= 0;
                if (fidx < 2048) lens[fidx] = bitcnt;
                fidx++;
                if (bitcnt >= 9 && hdr[8]) begin
                    if (hdr[7:6] == 2'b00 && hdr[5:4] == 2'b11) wen = 1;
                    else if (hdr[7:6] == 2'b00 && hdr[5:4] == 2'b00) wen = 0;
                    else if (hdr[7:6] == 2'b01 && bitcnt == 25 && wen) begin
                        mem[hdr[5:0]] = wdat; busy_left <= BUSY;
                    end
                end
            end
        end
    end

    task automatic req(input bit w, input int o, input logic [7:0] v,
                       output logic [7:0] rd, output bit er);
        while (busy) @(negedge clk);
        wr = w; off = o[7:0]; wdata = v; start = 1;
        @(negedge clk);
        start = 0;
        while (!done) @(negedge clk);
        rd = rdata; er = err;
        @(negedge clk);
    endtask

    function automatic logic [7:0] eb(input int o);
        return o[0] ? expm[o/2][15:8] : expm[o/2][7:0];
    endfunction

    task automatic put(input int o, input logic [7:0] v);
        if (o[0]) expm[o/2][15:8] = v;
        else      expm[o/2][7:0]  = v;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        bit er;
        int f0, b0, d0;
        for (int i = 0; i < 64; i++) expm[i] = wf(i);
        repeat (4) @(negedge clk);
        chk(!cs && !sclk && !mosi && !busy && !done, "R1 reset idle",
            {cs, sclk, mosi, busy, done}, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 R3: read sweep
        for (int o = 0; o < 128; o++) begin
            f0 = frames; b0 = fidx;
            req(0, o, 8'h00, rd, er);
            chk(rd == eb(o) && !er, "R2 read byte", rd, eb(o));
            if (o < 4) begin
                chk(frames - f0 == 1 && lens[b0] == 26, "R3 read frame clocks", lens[b0], 26);
                chk(!cs && !sclk && !mosi, "R1 idle between requests", {cs, sclk, mosi}, 0);
            end
        end

        // R5 R6 R7: write sweep
        for (int o = 0; o < 128; o++) begin
            logic [7:0] v;
            v = 8'(o * 29 + 7);
            f0 = frames; b0 = fidx;
            req(1, o, v, rd, er);
            put(o, v);
            chk(!er, "R7 write completes", er, 0);
            chk(mem[o/2] == expm[o/2], "R5 merged word", mem[o/2], expm[o/2]);
            chk(frames - f0 == 5, "R6 frame count", frames - f0, 5);
            chk(!wen, "R6 left disabled", wen, 0);
            if (o < 3)
                chk(lens[b0] == 9 && lens[b0+1] == 26 && lens[b0+2] == 25 &&
                    lens[b0+3] == 0 && lens[b0+4] == 9, "R3 R6 frame sequence",
                    lens[b0+2], 25);
        end
        for (int o = 0; o < 128; o++) begin
            req(0, o, 8'h00, rd, er);
            chk(rd == eb(o), "R5 readback", rd, eb(o));
        end

        // R9: out of range
        for (int k = 0; k < 4; k++) begin
            int o;
            o = (k == 0) ? 128 : (k == 1) ? 129 : (k == 2) ? 200 : 255;
            f0 = frames;
            req(1, o, 8'hAA, rd, er);
            chk(er == 1, "R9 reject err", er, 1);
            chk(frames == f0, "R9 pins untouched", frames - f0, 0);
        end

        // R10: start ignored while busy
        d0 = done_cnt;
        wr = 1; off = 8'd10; wdata = 8'hC3; start = 1;
        @(negedge clk);
        start = 0;
        repeat (20) @(negedge clk);
        chk(busy == 1, "R10 busy during write", busy, 1);
        wr = 1; off = 8'd11; wdata = 8'hEE; start = 1;
        @(negedge clk);
        start = 0;
        while (busy) @(negedge clk);
        repeat (10) @(negedge clk);
        put(10, 8'hC3);
        chk(done_cnt - d0 == 1, "R10 one done", done_cnt - d0, 1);
        req(0, 11, 8'h00, rd, er);
        chk(rd == eb(11), "R10 ignored write", rd, eb(11));
        req(0, 10, 8'h00, rd, er);
        chk(rd == 8'hC3, "R10 first write", rd, 8'hC3);

        // R8: timeout
        stuck = 1;
        f0 = frames;
        req(1, 20, 8'h5A, rd, er);
        put(20, 8'h5A);
        chk(er == 1, "R8 timeout err", er, 1);
        chk(frames - f0 == 4, "R8 no disable frame", frames - f0, 4);
        chk(!cs, "R8 cs low", cs, 0);
        stuck = 0;
        repeat (BUSY + 10) @(negedge clk);
        req(1, 21, 8'h77, rd, er);
        put(21, 8'h77);
        chk(!er, "R8 recovery write", er, 0);
        req(0, 20, 8'h00, rd, er);
        chk(rd == 8'h5A, "R8 data of aborted write", rd, 8'h5A);
        req(0, 21, 8'h00, rd, er);
        chk(rd == 8'h77, "R8 recovery read", rd, 8'h77);

        chk(min_low >= GAP, "R11 cs low gap", min_low, GAP);
        chk(viol == 0, "R4 mosi stable while sclk high", viol, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule